// File: doc/BRIEF.md
# Sample-Hold and Result Capture Sequencer

This block runs the acquisition loop for one channel built around an external successive-approximation converter. The converter has a busy output (called STATUS here) and a 16-bit parallel result bus. After each acquisition interval, the block issues a convert-start pulse of programmable width. In the same cycle that pulse rises, it drives a track/hold line to hold. This freezes the external sample-and-hold before the converter's internal reset disturbs its input.

The block keeps the sample-and-hold in hold until STATUS falls. On that falling edge it captures the result bus, optionally recodes it, presents it with a one-cycle valid strobe, and releases the sample-and-hold back to track. The time between samples is therefore the acquisition interval plus the start width plus the conversion time.

Two watchdogs abandon a conversion and raise a one-cycle error pulse:
- one fires if STATUS never rises after a start pulse;
- one fires if STATUS stays high for too long.

A free-running counter of captured words gives the throughput.

STATUS arrives from off-chip, so it passes through a synchroniser. The data bus is sampled only after the synchronised falling edge, which leaves many nanoseconds of settled data.

Top module: `daq_frontend_seq`

## Requirements
- R1: `conv_start` is high for exactly START_W consecutive cycles per conversion. The default of 7 cycles at 125 MHz gives 56 ns, which meets the 50 ns minimum.
- R2: `hold` rises in the same cycle as `conv_start` rises, and is high whenever `conv_start` is high.
- R3: `hold` stays high from the start pulse until the conversion ends, and falls in the cycle in which `data_valid` is high.
- R4: A 1-to-0 transition of `status` during a conversion captures `conv_data`. `data_valid` is a one-cycle pulse seen 3 cycles after `status` falls (2 synchroniser stages plus the capture register). `data_word` stays unchanged until the next capture.
- R5: `mode`, sampled at capture, selects the recoding. 2'd0 passes the bus unchanged. 2'd1 inverts all 16 bits (offset binary). 2'd2 inverts bits 14..0 and keeps bit 15 (two's complement). 2'd3 inverts bit 15 only (complementary two's complement).
- R6: The next `conv_start` rises exactly ACQ_CYC cycles after `hold` falls. This also applies to the first start after reset, counted from reset release.
- R7: If the synchronised `status` is not high within BUSY_WAIT cycles after `conv_start` falls, then:
  - `err` pulses for one cycle exactly BUSY_WAIT cycles after that fall;
  - `hold` falls in that same cycle;
  - no word is captured.
- R8: If `status` stays high for CONV_MAX cycles of conversion, `err` pulses for one cycle and `hold` falls. No word is captured.
- R9: `sample_count` increases by one in each cycle with `data_valid` high, and is unchanged otherwise.
- R10: A falling `status` while no conversion is in progress produces no `data_valid` and leaves `data_word` unchanged.
- R11: While `rst_n` is low, `conv_start`, `hold`, `data_valid` and `err` are low, and `sample_count` and `data_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status | input | 1 | Converter busy line, high while converting (asynchronous) |
| conv_data | input | 16 | Converter parallel result, complementary coded |
| mode | input | 2 | Recoding select, sampled at capture |
| conv_start | output | 1 | Convert-start pulse to the converter |
| hold | output | 1 | Sample-and-hold control, 1 = hold, 0 = track |
| data_word | output | 16 | Captured and recoded result |
| data_valid | output | 1 | One-cycle strobe aligned with a new `data_word` |
| sample_count | output | 16 | Count of captured words, wrapping |
| err | output | 1 | One-cycle pulse on a busy or conversion timeout |

## Verification
On every cycle, the bound assertions check the following:
- the start-pulse width;
- that hold rises with the start pulse and covers it;
- the exact acquisition gap before each start;
- that hold is released together with the valid strobe;
- the single-cycle strobe and that the word holds between captures;
- the counter step;
- that an error never comes with a capture or with hold still asserted.

Only the bench scenarios can show:
- that the right bus value is captured and recoded for each mode;
- the three-cycle capture latency after STATUS falls;
- the timing of each kind of timeout;
- that a stray STATUS fall after an aborted conversion is ignored.

// File: rtl/daq_seq_pkg.sv
// Package: shared types for the sample-hold and capture sequencer.
// Assumes: a converter result of up to 16 bits and a 2-bit mode select.
package daq_seq_pkg;

    // Recoding applied to the captured word
    typedef enum logic [1:0] {
        MODE_RAW    = 2'd0,
        MODE_OFFSET = 2'd1,
        MODE_TWOS   = 2'd2,
        MODE_CTWOS  = 2'd3
    } recode_e;

    // Sequencer phases
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2,
        ST_CONV  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/status_sync.sv
// Module: status_sync
// Brings the asynchronous converter busy line into the clock domain and
// derives a synchronised level and a one-cycle falling-edge indication.
// Assumes: STAGES >= 2 for metastability settling.
module status_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic status,
    output logic sts_lvl,
    output logic sts_fall
);

    logic [STAGES:0] chain;

    // Shift the raw line through the synchroniser and one extra edge stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], status};
    end

    assign sts_lvl  = chain[STAGES-1];
    assign sts_fall = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Phase controller: track interval, start pulse, wait for busy, conversion.
// One shared interval counter times every phase. It raises a capture
// request on the busy falling edge and a timeout on a missing or stuck busy.
// Assumes: all interval parameters >= 1.
module seq_fsm
    import daq_seq_pkg::*;
#(
    parameter int START_W   = 7,
    parameter int ACQ_CYC   = 12,
    parameter int BUSY_WAIT = 6,
    parameter int CONV_MAX  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sts_lvl,
    input  logic sts_fall,
    output logic conv_start,
    output logic hold,
    output logic capture,
    output logic timeout
);

    localparam int MAX_A = (START_W > ACQ_CYC) ? START_W : ACQ_CYC;
    localparam int MAX_B = (BUSY_WAIT > CONV_MAX) ? BUSY_WAIT : CONV_MAX;
    localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAXC + 1);

    localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYC - 1);
    localparam logic [CW-1:0] START_LAST = CW'(START_W - 1);
    localparam logic [CW-1:0] BUSY_LAST = CW'(BUSY_WAIT - 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_MAX - 1);

    seq_state_e      state, state_nx;
    logic [CW-1:0]   cnt, cnt_nx;

    // Next-phase and counter decision, plus capture and timeout requests
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + 1'b1;
        capture  = 1'b0;
        timeout  = 1'b0;
        unique case (state)
            ST_TRACK: if (cnt == ACQ_LAST) begin
                state_nx = ST_START;
                cnt_nx   = '0;
            end
            ST_START: if (cnt == START_LAST) begin
                state_nx = ST_WAIT;
                cnt_nx   = '0;
            end
            ST_WAIT: begin
                if (sts_lvl) begin
                    state_nx = ST_CONV;
                    cnt_nx   = '0;
                end else if (cnt == BUSY_LAST) begin
                    timeout  = 1'b1;
                    state_nx = ST_TRACK;
                    cnt_nx   = '0;
                end
            end
            ST_CONV: begin
                if (sts_fall) begin
                    capture  = 1'b1;
                    state_nx = ST_TRACK;
                    cnt_nx   = '0;
                end else if (cnt == CONV_LAST) begin
                    timeout  = 1'b1;
                    state_nx = ST_TRACK;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = ST_TRACK;
                cnt_nx   = '0;
            end
        endcase
    end

    // Phase and interval registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_TRACK;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign conv_start = (state == ST_START);
    assign hold       = (state != ST_TRACK);

endmodule

// File: rtl/result_recode.sv
// Module: result_recode
// Combinational recoding of the complementary-coded converter word.
// Assumes: W >= 2; the input is negative-true (complementary) coded.
module result_recode
    import daq_seq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  recode_e      mode,
    output logic [W-1:0] dout
);

    // Select the coding: pass, full invert, invert below MSB, invert MSB only
    always_comb begin
        unique case (mode)
            MODE_RAW:    dout = din;
            MODE_OFFSET: dout = ~din;
            MODE_TWOS:   dout = {din[W-1], ~din[W-2:0]};
            MODE_CTWOS:  dout = {~din[W-1], din[W-2:0]};
            default:     dout = din;
        endcase
    end

endmodule

// File: rtl/daq_frontend_seq.sv
// Module: daq_frontend_seq (top)
// Sample-hold and result capture sequencer for an SAR converter with a busy
// output. It issues timed convert-start pulses and drives the track/hold line.
// It captures the result on the busy falling edge, recodes it, and counts
// the captured words.
// Assumes: the result bus is stable from before busy falls until the next
// start, which covers the synchroniser delay.
module daq_frontend_seq
    import daq_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int START_W     = 7,
    parameter int ACQ_CYC     = 12,
    parameter int BUSY_WAIT   = 6,
    parameter int CONV_MAX    = 64,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [1:0]        mode,
    output logic              conv_start,
    output logic              hold,
    output logic [DATA_W-1:0] data_word,
    output logic              data_valid,
    output logic [CNT_W-1:0]  sample_count,
    output logic              err
);

    logic              sts_lvl, sts_fall;
    logic              capture, timeout;
    logic [DATA_W-1:0] recoded;

    status_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status),
        .sts_lvl  (sts_lvl),
        .sts_fall (sts_fall)
    );

    seq_fsm #(
        .START_W   (START_W),
        .ACQ_CYC   (ACQ_CYC),
        .BUSY_WAIT (BUSY_WAIT),
        .CONV_MAX  (CONV_MAX)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts_lvl    (sts_lvl),
        .sts_fall   (sts_fall),
        .conv_start (conv_start),
        .hold       (hold),
        .capture    (capture),
        .timeout    (timeout)
    );

    result_recode #(.W(DATA_W)) u_recode (
        .din  (conv_data),
        .mode (recode_e'(mode)),
        .dout (recoded)
    );

    // Result register, strobe, throughput counter and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_word    <= '0;
            data_valid   <= 1'b0;
            sample_count <= '0;
            err          <= 1'b0;
        end else begin
            data_valid <= capture;
            err        <= timeout;
            if (capture) begin
                data_word    <= recoded;
                sample_count <= sample_count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/daq_frontend_seq_chk.sv
// Module: daq_frontend_seq_chk
// Property checker bound to daq_frontend_seq. It watches the port-level
// timing of start, hold, capture and error.
// Assumes: the same interval parameters as the checked instance.
module daq_frontend_seq_chk #(
    parameter int DATA_W  = 16,
    parameter int START_W = 7,
    parameter int ACQ_CYC = 12,
    parameter int CNT_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_start,
    input logic              hold,
    input logic [DATA_W-1:0] data_word,
    input logic              data_valid,
    input logic [CNT_W-1:0]  sample_count,
    input logic              err
);

    logic [15:0] hi_cnt;
    logic [15:0] trk_cnt;

    // Count consecutive start-high cycles and consecutive track cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            trk_cnt <= '0;
        end else begin
            hi_cnt  <= conv_start ? hi_cnt + 1'b1 : 16'd0;
            trk_cnt <= hold ? 16'd0 : trk_cnt + 1'b1;
        end
    end

    AST_START_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_start) |-> hi_cnt == 16'(START_W));                  // R1
    AST_HOLD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_start) |-> $rose(hold));                             // R2
    AST_START_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> hold);                                           // R2
    AST_TRACK_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (!hold && $past(hold)));                         // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);                                    // R4
    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> $stable(data_word));                            // R4
    AST_ACQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_start) |-> trk_cnt == 16'(ACQ_CYC));                 // R6
    AST_ERR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!hold && !data_valid));                                // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> sample_count == $past(sample_count) + 1'b1);     // R9
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> $stable(sample_count));                         // R9

endmodule

bind daq_frontend_seq daq_frontend_seq_chk #(
    .DATA_W  (DATA_W),
    .START_W (START_W),
    .ACQ_CYC (ACQ_CYC),
    .CNT_W   (CNT_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start   (conv_start),
    .hold         (hold),
    .data_word    (data_word),
    .data_valid   (data_valid),
    .sample_count (sample_count),
    .err          (err)
);

// File: tb/test_daq_frontend_seq.sv
// Bench for daq_frontend_seq. A vector table of conversions is walked by one
// loop, then directed tests cover reset, timeouts and a stray busy edge.
module test_daq_frontend_seq;

    localparam int START_W   = 7;
    localparam int ACQ_CYC   = 12;
    localparam int BUSY_WAIT = 6;
    localparam int CONV_MAX  = 64;
    localparam int NVEC      = 8;

    // {mode[1:0], bus value[15:0], expected word[15:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd0, 16'h8000, 16'h8000},
        {2'd1, 16'h8000, 16'h7FFF},
        {2'd2, 16'h8000, 16'hFFFF},
        {2'd3, 16'h8000, 16'h0000},
        {2'd1, 16'h3A5C, 16'hC5A3},
        {2'd2, 16'h3A5C, 16'h45A3},
        {2'd3, 16'h0001, 16'h8001},
        {2'd2, 16'hFFFE, 16'h8001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        status = 1'b0;
    logic [15:0] conv_data = '0;
    logic [1:0]  mode = '0;
    logic        conv_start, hold, data_valid, err;
    logic [15:0] data_word, sample_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    daq_frontend_seq #(
        .START_W   (START_W),
        .ACQ_CYC   (ACQ_CYC),
        .BUSY_WAIT (BUSY_WAIT),
        .CONV_MAX  (CONV_MAX)
    ) i_daq_frontend_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .status       (status),
        .conv_data    (conv_data),
        .mode         (mode),
        .conv_start   (conv_start),
        .hold         (hold),
        .data_word    (data_word),
        .data_valid   (data_valid),
        .sample_count (sample_count),
        .err          (err)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Count negedges until conv_start is high
    task automatic wait_start(output int cyc);
        cyc = 0;
        while (!conv_start && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Check the start pulse itself and return once it has fallen
    task automatic pulse_checks();
        int w;
        check(hold == 1'b1, "R2 hold with start", 32'(hold), 1);
        w = 0;
        while (conv_start && w < 2000) begin
            @(negedge clk);
            w++;
        end
        check(w == START_W, "R1 start width", w, START_W);
    endtask

    // One full conversion with converter model; checks capture and recoding
    task automatic convert(input logic [33:0] v, input string tag);
        int lat;
        logic [15:0] cnt0;
        cnt0 = sample_count;
        @(negedge clk);
        status    = 1'b1;
        conv_data = v[31:16];
        mode      = v[33:32];
        repeat (10) @(negedge clk);
        check(hold == 1'b1, "R3 hold during conversion", 32'(hold), 1);
        status = 1'b0;
        lat = 0;
        while (!data_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 3, "R4 capture latency", lat, 3);
        check(data_word == v[15:0], tag, data_word, v[15:0]);
        check(hold == 1'b0, "R3 track at capture", 32'(hold), 0);
        check(sample_count == cnt0 + 16'd1, "R9 count step",
              sample_count, cnt0 + 16'd1);
        @(negedge clk);
        check(data_valid == 1'b0, "R4 single-cycle valid", 32'(data_valid), 0);
    endtask

    initial begin
        int cyc;
        int k;
        bit seen;
        logic [15:0] cnt0, word0;

        // R11 reset state
        repeat (4) @(negedge clk);
        check(conv_start == 0 && hold == 0 && data_valid == 0 && err == 0,
              "R11 reset controls", {conv_start, hold, data_valid, err}, 0);
        check(sample_count == 0 && data_word == 0, "R11 reset data",
              {sample_count, data_word}, 0);
        rst_n = 1'b1;

        // R6 first start counted from reset release
        wait_start(cyc);
        check(cyc == ACQ_CYC, "R6 first gap", cyc, ACQ_CYC);

        // Vector table: R5 recoding per mode
        for (int i = 0; i < NVEC; i++) begin
            if (i != 0) begin
                wait_start(cyc);
                check(cyc == ACQ_CYC - 1, "R6 acquisition gap", cyc, ACQ_CYC - 1);
            end
            pulse_checks();
            convert(VEC[i], "R5 recoded word");
        end

        // R7 busy never rises
        cnt0 = sample_count;
        wait_start(cyc);
        pulse_checks();
        k = 0;
        seen = 0;
        while (!err && k < 200) begin
            @(negedge clk);
            k++;
            if (data_valid) seen = 1;
        end
        check(k == BUSY_WAIT, "R7 busy timeout time", k, BUSY_WAIT);
        check(hold == 1'b0, "R7 hold released", 32'(hold), 0);
        check(!seen && sample_count == cnt0, "R7 no capture", sample_count, cnt0);
        @(negedge clk);
        check(err == 1'b0, "R7 err one cycle", 32'(err), 0);

        // R8 busy stuck high
        wait_start(cyc);
        pulse_checks();
        @(negedge clk);
        status = 1'b1;
        k = 0;
        seen = 0;
        while (!err && k < CONV_MAX + 40) begin
            @(negedge clk);
            k++;
            if (data_valid) seen = 1;
        end
        check(err == 1'b1, "R8 conversion timeout", 32'(err), 1);
        check(hold == 1'b0, "R8 hold released", 32'(hold), 0);
        check(!seen && sample_count == cnt0, "R8 no capture", sample_count, cnt0);

        // R10 stray busy fall while tracking, with a mode change
        word0 = data_word;
        mode  = 2'd1;
        conv_data = 16'h1234;
        status = 1'b0;
        seen = 0;
        repeat (6) begin
            @(negedge clk);
            if (data_valid) seen = 1;
        end
        check(!seen, "R10 no valid on stray fall", 32'(seen), 0);
        check(data_word == word0, "R10 word unchanged", data_word, word0);
        check(sample_count == cnt0, "R10 count unchanged", sample_count, cnt0);

        // Recovery after timeouts
        wait_start(cyc);
        pulse_checks();
        convert({2'd0, 16'h5555, 16'h5555}, "R5 recovery word");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule